// File: doc/BRIEF.md
# Paging Receiver Option Loader with Sync-Loss Hold Timer

This block takes the setup word of a paging-protocol receiver through a two-wire serial port. After a decoder reset pulse, software shifts exactly 192 option bits in, one per rising edge of the serial clock, with bit D0 first. A falling edge on the enable line, once all 192 bits are in, starts the decoder and locks the option register until the next decoder reset. From the stored word the block presents decoded fields:

- six 18-bit receive addresses, each with three function bits
- per-address enables
- a baud-rate code
- data-inversion and input-filter selects
- a preamble length in bits
- a sync-loss hold time in seconds

The same block runs a hold timer. While the decoder runs and sync is reported present, the "receiver active" flag is high and the timer is reloaded. Once sync is lost, the timer counts ticks of a one-second strobe. The flag drops when the selected hold time has elapsed.

The serial clock, serial data and enable line come from a slower domain. They pass through a parameterised synchronizer before any edge is detected.

Top module: `pgr_option_loader`

## Requirements
- R1: After `rst_n` low, `loaded`, `dec_run` and `rx_active` are 0, and every decoded field reads 0, except that `pre_bits` reads 512 and `hold_secs` reads 36, the values for code 00.
- R2: Each rising edge of `ser_clk` stores one `ser_dat` bit. The first bit stored is D0 and the 192nd is D191. `loaded` goes to 1 when the 192nd bit is stored.
- R3: Address k (k = 0..5, base b = 32k) is bits D(b+3)..D(b+20), with D(b+3) as `addr_flat` bit 18k+17 and D(b+20) as bit 18k. Its function bits are D(b+21)..D(b+23), with D(b+21) as `func_flat` bit 3k+2 and D(b+23) as bit 3k.
- R4: `baud_sel` = {D24,D25}, `invert` = D26, `schmitt` = D29, `addr_en[k]` = D(56+k), `hold_code` = {D120,D121}, and the preamble code is {D122,D123}.
- R5: `pre_bits` is 512, 896, 1024 or 1792 for preamble codes 00, 01, 10 and 11.
- R6: Serial clocks after the 192nd bit change no field, and `loaded` stays 1.
- R7: A falling edge of `run_en` while `loaded` is 1 sets `dec_run`. A falling edge while `loaded` is 0 leaves `dec_run` at 0.
- R8: While `dec_run` is 1, serial clocks change no field.
- R9: A `dec_rst` pulse clears the stored word, the bit counter, `dec_run` and `rx_active`, and a new 192-bit load then works as from reset.
- R10: `hold_secs` follows `hold_code`. With `baud_sel` 00 the values are 36, 72, 144 and 288 for codes 00..11; with any other `baud_sel` they are 31, 61, 123 and 246. While `dec_run` is 1, `rx_active` rises only after `sync_ok` has been seen. With `sync_ok` low, it falls on the `hold_secs`-th `tick` pulse and not before.
- R11: `sync_ok` high while `dec_run` is 1 reloads the hold count, so a later loss of sync again takes the full `hold_secs` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rst | input | 1 | Synchronous decoder reset pulse, active high |
| ser_clk | input | 1 | Serial option clock, sampled; bits taken on its rising edge |
| ser_dat | input | 1 | Serial option data |
| run_en | input | 1 | Enable line; its falling edge after loading starts the decoder |
| sync_ok | input | 1 | Sync-present indication from the decoder |
| tick | input | 1 | One-cycle pulse per second of hold time |
| loaded | output | 1 | All 192 option bits stored |
| dec_run | output | 1 | Decoder started; option word locked |
| rx_active | output | 1 | Receiver active flag driven by the hold timer |
| addr_flat | output | 108 | Six 18-bit addresses, address k at bits 18k+17..18k |
| func_flat | output | 18 | Six 3-bit function fields, address k at bits 3k+2..3k |
| addr_en | output | 6 | Per-address enables |
| baud_sel | output | 2 | Baud-rate code |
| invert | output | 1 | Data inversion select |
| schmitt | output | 1 | Input filter select |
| hold_code | output | 2 | Sync-loss hold-time code |
| pre_bits | output | 11 | Preamble length in bits |
| hold_secs | output | 9 | Selected hold time in seconds |

## Verification
The assertions assume that `dec_rst`, `sync_ok` and `tick` are synchronous to `clk`. They also assume that `ser_clk` and `run_en` change slowly enough for every level to pass through the synchronizer before the next edge. The stimulus keeps each serial clock phase at least four core cycles long and holds `ser_dat` steady across the rising edge. It drives every input on the falling core-clock edge. Tick pulses are one cycle wide and spaced by an idle cycle, so a reload and a count step never share a cycle unless a check intends it.

// File: rtl/pgr_opt_pkg.sv
package pgr_opt_pkg;

   localparam int HOLD_W = 9;
   localparam int PRE_W  = 11;

   // Bit positions of the single control fields inside the option word
   localparam int POS_BAUD    = 24;
   localparam int POS_INV     = 26;
   localparam int POS_SCHMITT = 29;
   localparam int POS_EN      = 56;
   localparam int POS_HOLD    = 120;
   localparam int POS_PRE     = 122;

   function automatic logic [HOLD_W-1:0] hold_secs_f(input logic [1:0] baud,
                                                     input logic [1:0] code);
      logic [HOLD_W-1:0] r;
      if (baud == 2'b00) begin
         case (code)
            2'd0:    r = HOLD_W'(36);
            2'd1:    r = HOLD_W'(72);
            2'd2:    r = HOLD_W'(144);
            default: r = HOLD_W'(288);
         endcase
      end else begin
         case (code)
            2'd0:    r = HOLD_W'(31);
            2'd1:    r = HOLD_W'(61);
            2'd2:    r = HOLD_W'(123);
            default: r = HOLD_W'(246);
         endcase
      end
      return r;
   endfunction

   function automatic logic [PRE_W-1:0] pre_bits_f(input logic [1:0] code);
      logic [PRE_W-1:0] r;
      case (code)
         2'd0:    r = PRE_W'(512);
         2'd1:    r = PRE_W'(896);
         2'd2:    r = PRE_W'(1024);
         default: r = PRE_W'(1792);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/opt_in_sync.sv
module opt_in_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (WIDTH < 1 || STAGES < 0) begin : g_bad_cfg
         $error("opt_in_sync: WIDTH must be >= 1 and STAGES >= 0");
      end

      if (STAGES == 0) begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= d_i;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q_o = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/opt_shift_reg.sv
module opt_shift_reg #(
   parameter int OPT_BITS = 192,
   localparam int CNT_W   = $clog2(OPT_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                lock_i,
   input  logic                sclk_i,
   input  logic                sdat_i,
   output logic [OPT_BITS-1:0] opt_o,
   output logic                full_o
);

   logic [OPT_BITS-1:0] opt_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                sclk_prev;
   logic                full;
   logic                take;

   generate
      if (OPT_BITS < 2) begin : g_bad_bits
         $error("opt_shift_reg: OPT_BITS must be >= 2");
      end
   endgenerate

   assign full = (cnt_q == CNT_W'(OPT_BITS));
   assign take = sclk_i & ~sclk_prev & ~lock_i & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_i;
   end

   // First bit in ends at position 0 after OPT_BITS shifts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_q <= '0;
         cnt_q <= '0;
      end else if (clr_i) begin
         opt_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         opt_q <= {sdat_i, opt_q[OPT_BITS-1:1]};
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign opt_o  = opt_q;
   assign full_o = full;

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(OPT_BITS));

   assert_full_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr_i) |=> $stable(opt_q));

   assert_lock_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i && !clr_i) |=> $stable(opt_q));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0 && opt_q == '0));

endmodule

// File: rtl/opt_field_map.sv
module opt_field_map
   import pgr_opt_pkg::*;
#(
   parameter int OPT_BITS = 192,
   parameter int N_ADDR   = 6,
   parameter int SLOT     = 32,
   parameter int ADDR_OFS = 3,
   parameter int ADDR_W   = 18,
   parameter int FUNC_W   = 3
) (
   input  logic [OPT_BITS-1:0]        opt_i,
   output logic [N_ADDR*ADDR_W-1:0]   addr_o,
   output logic [N_ADDR*FUNC_W-1:0]   func_o,
   output logic [N_ADDR-1:0]          en_o,
   output logic [1:0]                 baud_o,
   output logic                       inv_o,
   output logic                       schmitt_o,
   output logic [1:0]                 hold_code_o,
   output logic [PRE_W-1:0]           pre_bits_o
);

   localparam int FIELD_END = ADDR_OFS + ADDR_W + FUNC_W;

   generate
      if (N_ADDR * SLOT > OPT_BITS || FIELD_END > SLOT) begin : g_bad_slots
         $error("opt_field_map: address slots do not fit the option word");
      end
      if (POS_EN + N_ADDR > OPT_BITS || POS_PRE + 2 > OPT_BITS) begin : g_bad_ctrl
         $error("opt_field_map: control fields outside the option word");
      end
   endgenerate

   // Whole-word reduction keeps the bits no field decodes visibly consumed
   logic unused_opt;
   assign unused_opt = ^opt_i;

   generate
      for (genvar k = 0; k < N_ADDR; k++) begin : g_slot
         localparam int BASE = k * SLOT + ADDR_OFS;
         // Address sent most significant bit first
         for (genvar j = 0; j < ADDR_W; j++) begin : g_abit
            assign addr_o[k*ADDR_W + j] = opt_i[BASE + ADDR_W - 1 - j];
         end
         for (genvar j = 0; j < FUNC_W; j++) begin : g_fbit
            assign func_o[k*FUNC_W + FUNC_W - 1 - j] = opt_i[BASE + ADDR_W + j];
         end
         assign en_o[k] = opt_i[POS_EN + k];
      end
   endgenerate

   logic [1:0] pre_code;

   assign baud_o      = {opt_i[POS_BAUD], opt_i[POS_BAUD+1]};
   assign inv_o       = opt_i[POS_INV];
   assign schmitt_o   = opt_i[POS_SCHMITT];
   assign hold_code_o = {opt_i[POS_HOLD], opt_i[POS_HOLD+1]};
   assign pre_code    = {opt_i[POS_PRE], opt_i[POS_PRE+1]};
   assign pre_bits_o  = pre_bits_f(pre_code);

endmodule

// File: rtl/opt_hold_timer.sv
module opt_hold_timer
   import pgr_opt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              run_i,
   input  logic              sync_i,
   input  logic              tick_i,
   input  logic [HOLD_W-1:0] secs_i,
   output logic              active_o
);

   logic [HOLD_W-1:0] remain_q;
   logic              active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         active_q <= 1'b0;
      end else if (clr_i || !run_i) begin
         remain_q <= '0;
         active_q <= 1'b0;
      end else if (sync_i) begin
         remain_q <= secs_i;
         active_q <= 1'b1;
      end else if (tick_i && active_q) begin
         if (remain_q <= HOLD_W'(1)) begin
            remain_q <= '0;
            active_q <= 1'b0;
         end else begin
            remain_q <= remain_q - HOLD_W'(1);
         end
      end
   end

   assign active_o = active_q;

   assert_active_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> run_i);

   assert_no_early_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && run_i && !clr_i && !tick_i) |=> active_q);

   assert_sync_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && sync_i && !clr_i) |=> (active_q && remain_q == $past(secs_i)));

endmodule

// File: rtl/pgr_option_loader.sv
module pgr_option_loader
   import pgr_opt_pkg::*;
#(
   parameter int OPT_BITS    = 192,
   parameter int N_ADDR      = 6,
   parameter int SLOT        = 32,
   parameter int ADDR_OFS    = 3,
   parameter int ADDR_W      = 18,
   parameter int FUNC_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       dec_rst,
   input  logic                       ser_clk,
   input  logic                       ser_dat,
   input  logic                       run_en,
   input  logic                       sync_ok,
   input  logic                       tick,
   output logic                       loaded,
   output logic                       dec_run,
   output logic                       rx_active,
   output logic [N_ADDR*ADDR_W-1:0]   addr_flat,
   output logic [N_ADDR*FUNC_W-1:0]   func_flat,
   output logic [N_ADDR-1:0]          addr_en,
   output logic [1:0]                 baud_sel,
   output logic                       invert,
   output logic                       schmitt,
   output logic [1:0]                 hold_code,
   output logic [PRE_W-1:0]           pre_bits,
   output logic [HOLD_W-1:0]          hold_secs
);

   logic [2:0]          slow_raw;
   logic [2:0]          slow_s;
   logic                sclk_s, sdat_s, run_s;
   logic                run_prev;
   logic                run_fall;
   logic                running_q;
   logic                full;
   logic [OPT_BITS-1:0] opt_word;

   assign slow_raw = {run_en, ser_dat, ser_clk};

   opt_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (slow_raw),
      .q_o   (slow_s)
   );

   assign sclk_s = slow_s[0];
   assign sdat_s = slow_s[1];
   assign run_s  = slow_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_prev <= 1'b0;
      else        run_prev <= run_s;
   end

   assign run_fall = run_prev & ~run_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                running_q <= 1'b0;
      else if (dec_rst)          running_q <= 1'b0;
      else if (run_fall && full) running_q <= 1'b1;
   end

   opt_shift_reg #(.OPT_BITS(OPT_BITS)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (dec_rst),
      .lock_i (running_q),
      .sclk_i (sclk_s),
      .sdat_i (sdat_s),
      .opt_o  (opt_word),
      .full_o (full)
   );

   opt_field_map #(
      .OPT_BITS (OPT_BITS),
      .N_ADDR   (N_ADDR),
      .SLOT     (SLOT),
      .ADDR_OFS (ADDR_OFS),
      .ADDR_W   (ADDR_W),
      .FUNC_W   (FUNC_W)
   ) u_map (
      .opt_i       (opt_word),
      .addr_o      (addr_flat),
      .func_o      (func_flat),
      .en_o        (addr_en),
      .baud_o      (baud_sel),
      .inv_o       (invert),
      .schmitt_o   (schmitt),
      .hold_code_o (hold_code),
      .pre_bits_o  (pre_bits)
   );

   assign hold_secs = hold_secs_f(baud_sel, hold_code);

   opt_hold_timer u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (dec_rst),
      .run_i    (running_q),
      .sync_i   (sync_ok),
      .tick_i   (tick),
      .secs_i   (hold_secs),
      .active_o (rx_active)
   );

   assign loaded  = full;
   assign dec_run = running_q;

   assert_run_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running_q) |-> full);

   assert_run_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_rst |=> (!running_q && !full && !rx_active));

endmodule

// File: tb/sim_pgr_option_loader.sv
module sim_pgr_option_loader;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dec_rst = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, run_en = 1'b0;
   logic sync_ok = 1'b0, tick = 1'b0;
   logic loaded, dec_run, rx_active, invert, schmitt;
   logic [107:0] addr_flat;
   logic [17:0]  func_flat;
   logic [5:0]   addr_en;
   logic [1:0]   baud_sel, hold_code;
   logic [10:0]  pre_bits;
   logic [8:0]   hold_secs;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pgr_option_loader u0 (
      .clk(clk), .rst_n(rst_n), .dec_rst(dec_rst), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .run_en(run_en), .sync_ok(sync_ok), .tick(tick),
      .loaded(loaded), .dec_run(dec_run), .rx_active(rx_active),
      .addr_flat(addr_flat), .func_flat(func_flat), .addr_en(addr_en),
      .baud_sel(baud_sel), .invert(invert), .schmitt(schmitt),
      .hold_code(hold_code), .pre_bits(pre_bits), .hold_secs(hold_secs)
   );

   // Configuration under test, kept by the bench
   logic [17:0]  e_addr [6];
   logic [2:0]   e_func [6];
   logic [5:0]   e_en;
   logic [1:0]   e_baud, e_hold, e_pre;
   logic         e_inv, e_sch;
   logic [191:0] vec;

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [107:0] exp_addr();
      logic [107:0] r;
      for (int k = 0; k < 6; k++) r[k*18 +: 18] = e_addr[k];
      return r;
   endfunction

   function automatic logic [17:0] exp_func();
      logic [17:0] r;
      for (int k = 0; k < 6; k++) r[k*3 +: 3] = e_func[k];
      return r;
   endfunction

   function automatic logic [10:0] exp_pre(input logic [1:0] c);
      case (c)
         2'd0: return 11'd512;
         2'd1: return 11'd896;
         2'd2: return 11'd1024;
         default: return 11'd1792;
      endcase
   endfunction

   function automatic logic [8:0] exp_hold(input logic [1:0] b, input logic [1:0] c);
      if (b == 2'b00) begin
         case (c)
            2'd0: return 9'd36;
            2'd1: return 9'd72;
            2'd2: return 9'd144;
            default: return 9'd288;
         endcase
      end
      case (c)
         2'd0: return 9'd31;
         2'd1: return 9'd61;
         2'd2: return 9'd123;
         default: return 9'd246;
      endcase
   endfunction

   // Bit placement taken from R3 and R4
   task automatic build_vec();
      vec = '0;
      for (int k = 0; k < 6; k++) begin
         for (int j = 0; j < 18; j++) vec[32*k + 3 + j] = e_addr[k][17-j];
         for (int j = 0; j < 3; j++)  vec[32*k + 21 + j] = e_func[k][2-j];
         vec[56 + k] = e_en[k];
      end
      vec[24] = e_baud[1];  vec[25] = e_baud[0];
      vec[26] = e_inv;      vec[29] = e_sch;
      vec[120] = e_hold[1]; vec[121] = e_hold[0];
      vec[122] = e_pre[1];  vec[123] = e_pre[0];
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) ser_dat = b;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_range(input int lo, input int hi);
      for (int i = lo; i < hi; i++) send_bit(vec[i]);
   endtask

   task automatic pulse_dec_rst();
      @(negedge clk) dec_rst = 1'b1;
      repeat (2) @(negedge clk);
      dec_rst = 1'b0;
      run_en = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic fall_run();
      @(negedge clk) run_en = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic chk_fields(input string req);
      chk({req, " addr"}, 128'(addr_flat), 128'(exp_addr()));
      chk({req, " func"}, 128'(func_flat), 128'(exp_func()));
      chk({req, " en"}, 128'(addr_en), 128'(e_en));
      chk({req, " ctrl"}, 128'({baud_sel, invert, schmitt, hold_code}),
          128'({e_baud, e_inv, e_sch, e_hold}));
   endtask

   task automatic set_pattern1();
      e_addr[0] = 18'h2A5C3; e_addr[1] = 18'h1F00F; e_addr[2] = 18'h3C001;
      e_addr[3] = 18'h00ABC; e_addr[4] = 18'h35555; e_addr[5] = 18'h20001;
      e_func[0] = 3'b101; e_func[1] = 3'b011; e_func[2] = 3'b100;
      e_func[3] = 3'b001; e_func[4] = 3'b110; e_func[5] = 3'b111;
      e_en = 6'b101101; e_baud = 2'b00; e_inv = 1'b1; e_sch = 1'b0;
      e_hold = 2'b01; e_pre = 2'b10;
   endtask

   task automatic set_pattern2();
      e_addr[0] = 18'h12345; e_addr[1] = 18'h3FFFE; e_addr[2] = 18'h0F0F0;
      e_addr[3] = 18'h2DB6D; e_addr[4] = 18'h00001; e_addr[5] = 18'h1AAAA;
      e_func[0] = 3'b010; e_func[1] = 3'b100; e_func[2] = 3'b111;
      e_func[3] = 3'b000; e_func[4] = 3'b101; e_func[5] = 3'b011;
      e_en = 6'b010011; e_baud = 2'b10; e_inv = 1'b0; e_sch = 1'b1;
      e_hold = 2'b11; e_pre = 2'b01;
   endtask

   task automatic t_reset_state();
      chk("R1 loaded", 128'(loaded), 128'(0));
      chk("R1 dec_run", 128'(dec_run), 128'(0));
      chk("R1 rx_active", 128'(rx_active), 128'(0));
      chk("R1 addr", 128'(addr_flat), 128'(0));
      chk("R1 pre_bits", 128'(pre_bits), 128'(512));
      chk("R1 hold_secs", 128'(hold_secs), 128'(36));
   endtask

   task automatic t_load_with_early_fall();
      set_pattern1();
      build_vec();
      pulse_dec_rst();
      send_range(0, 100);
      chk("R2 not loaded mid", 128'(loaded), 128'(0));
      fall_run();
      chk("R7 early fall ignored", 128'(dec_run), 128'(0));
      @(negedge clk) run_en = 1'b1;
      repeat (6) @(negedge clk);
      send_range(100, 191);
      chk("R2 not loaded at 191", 128'(loaded), 128'(0));
      send_range(191, 192);
      chk("R2 loaded", 128'(loaded), 128'(1));
      chk_fields("R3 R4 pattern1");
      chk("R5 pre 10", 128'(pre_bits), 128'(exp_pre(e_pre)));
      chk("R10 hold secs p1", 128'(hold_secs), 128'(exp_hold(e_baud, e_hold)));
   endtask

   task automatic t_extra_clocks();
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      chk("R6 still loaded", 128'(loaded), 128'(1));
      chk_fields("R6 extra clocks");
   endtask

   task automatic t_run_and_lock();
      fall_run();
      chk("R7 run started", 128'(dec_run), 128'(1));
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      chk_fields("R8 locked");
      chk("R8 pre", 128'(pre_bits), 128'(exp_pre(e_pre)));
   endtask

   task automatic t_hold(input string req);
      int n;
      n = int'(exp_hold(e_baud, e_hold));
      repeat (3) pulse_tick();
      chk({req, " R10 idle before sync"}, 128'(rx_active), 128'(0));
      @(negedge clk) sync_ok = 1'b1;
      repeat (3) @(negedge clk);
      chk({req, " R10 active with sync"}, 128'(rx_active), 128'(1));
      sync_ok = 1'b0;
      @(negedge clk);
      for (int i = 0; i < n - 1; i++) pulse_tick();
      chk({req, " R10 held until last tick"}, 128'(rx_active), 128'(1));
      pulse_tick();
      chk({req, " R10 dropped at hold"}, 128'(rx_active), 128'(0));
      @(negedge clk) sync_ok = 1'b1;
      repeat (2) @(negedge clk);
      sync_ok = 1'b0;
      for (int i = 0; i < n / 2; i++) pulse_tick();
      @(negedge clk) sync_ok = 1'b1;
      repeat (2) @(negedge clk);
      sync_ok = 1'b0;
      for (int i = 0; i < n - 1; i++) pulse_tick();
      chk({req, " R11 reload full period"}, 128'(rx_active), 128'(1));
      pulse_tick();
      chk({req, " R11 dropped after reload"}, 128'(rx_active), 128'(0));
   endtask

   task automatic t_dec_reset_reload();
      @(negedge clk) sync_ok = 1'b1;
      repeat (2) @(negedge clk);
      pulse_dec_rst();
      sync_ok = 1'b0;
      chk("R9 loaded cleared", 128'(loaded), 128'(0));
      chk("R9 dec_run cleared", 128'(dec_run), 128'(0));
      chk("R9 rx_active cleared", 128'(rx_active), 128'(0));
      chk("R9 addr cleared", 128'(addr_flat), 128'(0));
      set_pattern2();
      build_vec();
      send_range(0, 192);
      chk("R9 reload loaded", 128'(loaded), 128'(1));
      chk_fields("R9 R3 R4 pattern2");
      chk("R5 pre 01", 128'(pre_bits), 128'(exp_pre(e_pre)));
      chk("R10 hold secs p2", 128'(hold_secs), 128'(exp_hold(e_baud, e_hold)));
      fall_run();
      chk("R7 run p2", 128'(dec_run), 128'(1));
   endtask

   task automatic t_code_tables();
      for (int c = 0; c < 4; c++) begin
         pulse_dec_rst();
         e_pre = 2'(c);
         e_hold = 2'(3 - c);
         e_baud = (c % 2 == 1) ? 2'b01 : 2'b00;
         build_vec();
         send_range(0, 192);
         chk("R5 pre table", 128'(pre_bits), 128'(exp_pre(e_pre)));
         chk("R10 hold table", 128'(hold_secs), 128'(exp_hold(e_baud, e_hold)));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      t_load_with_early_fall();
      t_extra_clocks();
      t_run_and_lock();
      t_hold("p1");
      t_dec_reset_reload();
      t_hold("p2");
      t_code_tables();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule